// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two strobes that frame every external memory transfer of an 8-bit microcontroller. The strobes are the address-latch pulse (`ale`) and the active-low code-read strobe (`psen_n`). It also produces a flag that tells the address/data multiplexer when the shared bus carries an address. It runs on the oscillator clock. It keeps its own phase counter over a machine cycle of twelve clocks, and each machine cycle holds two identical half-cycles of six clocks. In normal operation `ale` therefore pulses at one sixth of the oscillator rate.

At each machine-cycle boundary the core presents the cycle kind, the ALE-disable register bit and the external-execution status. The block samples all three at that boundary and holds them for the whole cycle. The cycle kind selects one of four strobe patterns:

- An internal fetch leaves `psen_n` idle.
- An external code fetch and a code-table read both strobe `psen_n` twice.
- An external data access drops the second address pulse and both code-read strobes.

The ALE-disable bit silences the free-running pulses. It has no effect on data-access or table-read cycles, and none at all while code runs from external memory.

Top module: `ext_bus_strobe`

## Requirements
- R1: While `rst_n` is low, `ale` is 0, `psen_n` is 1, `addr_slot` is 0 and `cyc_phase` is 11 (the last phase). The first rising edge after release starts phase 0.
- R2: `cyc_phase` counts 0,1,…,11 and then wraps to 0, advancing by one on every clock.
- R3: In a cycle whose ALE is enabled, `ale` is high in phases 0, 1, 6 and 7 and low elsewhere. `cyc_kind` encodes the cycle kinds as 00 for internal fetch, 01 for external code fetch, 10 for external data access and 11 for code-table read.
- R4: In an external data access cycle (`cyc_kind`=10), `ale` is high only in phases 0 and 1. The pulse at phases 6–7 is dropped.
- R5: With `ale_off`=1 and `ext_exec`=0, `ale` stays low for the whole of an internal fetch or external code fetch cycle. Data-access and table-read cycles still pulse as in R3/R4.
- R6: With `ext_exec`=1, `ale_off` has no effect, and `ale` follows R3/R4.
- R7: In external code fetch and code-table read cycles, `psen_n` is low in phases 3–5 and 9–11 and high elsewhere. It is never low while `ale` is high.
- R8: `psen_n` stays high for the whole of an internal fetch cycle and of an external data access cycle.
- R9: `addr_slot` is high in phases 0–2 and 6–8, independent of `ale_off`. In an external data access cycle only phases 0–2 are marked.
- R10: `cyc_kind`, `ale_off` and `ext_exec` are sampled only at the edge that starts phase 0. Changes during a machine cycle do not alter that cycle's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_kind | input | 2 | Kind of the next machine cycle (00 int fetch, 01 ext fetch, 10 ext data, 11 table read) |
| ale_off | input | 1 | ALE-disable register bit |
| ext_exec | input | 1 | Core is executing from external program memory |
| ale | output | 1 | Address latch enable strobe |
| psen_n | output | 1 | Active-low external code read strobe |
| addr_slot | output | 1 | Bus currently carries an address |
| cyc_phase | output | 4 | Phase within the 12-clock machine cycle |

## Verification
Two rules can act on `ale` in the same machine cycle: the disable bit and the data-access pulse drop. The bench sweeps all sixteen combinations of cycle kind, `ale_off` and `ext_exec`. It therefore includes a data-access cycle with the disable bit set and execution internal, where the first pulse must survive and the second must be absent. It also includes the same cycle with `ext_exec` raised, where the result must be identical. The sweep is then repeated with every control inverted mid-cycle, so that a design that samples late mixes two configurations and is caught. Every phase of every cycle is compared against a pattern computed arithmetically from the phase number.

// File: rtl/bus_strobe_pkg.sv
// Package: shared types for the external bus strobe generator.
// Assumes a 2-bit cycle-kind code supplied by the core.
package bus_strobe_pkg;

    typedef enum logic [1:0] {
        CK_INT_FETCH = 2'b00,
        CK_EXT_FETCH = 2'b01,
        CK_EXT_DATA  = 2'b10,
        CK_TABLE_RD  = 2'b11
    } cyc_kind_e;

    typedef struct packed {
        cyc_kind_e kind;
        logic      ale_off;
        logic      ext_exec;
    } cyc_cfg_t;

endpackage

// File: rtl/mc_phase_ctr.sv
// Machine-cycle phase counter. Counts 0..MC_CLKS-1 and captures the
// cycle configuration at the boundary into phase 0.
// Assumes MC_CLKS >= 2; reset parks the counter on the last phase.
module mc_phase_ctr #(
    parameter int MC_CLKS = 12,
    localparam int PH_W   = $clog2(MC_CLKS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  bus_strobe_pkg::cyc_cfg_t      cfg_in,
    output logic [PH_W-1:0]               ph_q,
    output logic [PH_W-1:0]               ph_nxt,
    output bus_strobe_pkg::cyc_cfg_t      cfg_q,
    output bus_strobe_pkg::cyc_cfg_t      cfg_nxt
);
    import bus_strobe_pkg::*;

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(MC_CLKS - 1);
    localparam cyc_cfg_t CFG_RST = '{kind: CK_INT_FETCH, ale_off: 1'b0, ext_exec: 1'b0};

    logic at_last;

    // Next phase and next configuration; sampling happens only at wrap.
    always_comb begin
        at_last = (ph_q == PH_LAST);
        ph_nxt  = at_last ? '0 : ph_q + PH_W'(1);
        cfg_nxt = at_last ? cfg_in : cfg_q;
    end

    // Phase and configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_LAST;
            cfg_q <= CFG_RST;
        end else begin
            ph_q  <= ph_nxt;
            cfg_q <= cfg_nxt;
        end
    end

endmodule

// File: rtl/strobe_decode.sv
// Strobe decoder. Maps a phase and a cycle configuration to the ale,
// psen_n and address-slot levels. Purely combinational.
// Assumes an even MC_CLKS with two equal half-cycles, and ALE_W+1 < MC_CLKS/2.
module strobe_decode #(
    parameter int MC_CLKS = 12,
    parameter int ALE_W   = 2,
    localparam int PH_W   = $clog2(MC_CLKS)
) (
    input  logic [PH_W-1:0]          ph,
    input  bus_strobe_pkg::cyc_cfg_t cfg,
    output logic                     ale,
    output logic                     psen_n,
    output logic                     addr_slot
);
    import bus_strobe_pkg::*;

    localparam int HALF     = MC_CLKS / 2;
    localparam int ADDR_W   = ALE_W + 1;
    localparam int PSEN_OFS = ADDR_W;
    localparam logic [PH_W-1:0] HALF_P   = PH_W'(HALF);
    localparam logic [PH_W-1:0] ALE_END  = PH_W'(ALE_W);
    localparam logic [PH_W-1:0] ADDR_END = PH_W'(ADDR_W);
    localparam logic [PH_W-1:0] PSEN_P   = PH_W'(PSEN_OFS);

    logic            second;
    logic [PH_W-1:0] hp;
    logic            slot_live;
    logic            ale_en;
    logic            code_rd;

    // Decode the half-cycle position and the per-cycle strobe permissions.
    always_comb begin
        second    = (ph >= HALF_P);
        hp        = second ? ph - HALF_P : ph;
        slot_live = !(second && cfg.kind == CK_EXT_DATA);
        ale_en    = cfg.ext_exec || !cfg.ale_off ||
                    cfg.kind == CK_EXT_DATA || cfg.kind == CK_TABLE_RD;
        code_rd   = (cfg.kind == CK_EXT_FETCH) || (cfg.kind == CK_TABLE_RD);
        ale       = slot_live && ale_en && (hp < ALE_END);
        addr_slot = slot_live && (hp < ADDR_END);
        psen_n    = !(code_rd && (hp >= PSEN_P));
    end

endmodule

// File: rtl/ext_bus_strobe.sv
// External bus strobe generator (top). Produces ALE, active-low PSEN and
// an address-slot flag for each 12-clock machine cycle.
// Assumes the core holds cycle controls valid at the phase-0 boundary.
// REG_OUT=1 drives the strobes from flops; REG_OUT=0 decodes them directly.
module ext_bus_strobe #(
    parameter int MC_CLKS = 12,
    parameter int ALE_W   = 2,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   cyc_kind,
    input  logic                         ale_off,
    input  logic                         ext_exec,
    output logic                         ale,
    output logic                         psen_n,
    output logic                         addr_slot,
    output logic [$clog2(MC_CLKS)-1:0]   cyc_phase
);
    import bus_strobe_pkg::*;

    localparam int PH_W = $clog2(MC_CLKS);

    cyc_cfg_t        cfg_in;
    cyc_cfg_t        cfg_q;
    cyc_cfg_t        cfg_nxt;
    logic [PH_W-1:0] ph_q;
    logic [PH_W-1:0] ph_nxt;

    // Pack the core controls into one configuration word.
    always_comb begin
        cfg_in.kind     = cyc_kind_e'(cyc_kind);
        cfg_in.ale_off  = ale_off;
        cfg_in.ext_exec = ext_exec;
    end

    mc_phase_ctr #(.MC_CLKS(MC_CLKS)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_in  (cfg_in),
        .ph_q    (ph_q),
        .ph_nxt  (ph_nxt),
        .cfg_q   (cfg_q),
        .cfg_nxt (cfg_nxt)
    );

    assign cyc_phase = ph_q;

    generate
        if (REG_OUT) begin : g_reg
            logic ale_d, psen_n_d, addr_d;

            strobe_decode #(.MC_CLKS(MC_CLKS), .ALE_W(ALE_W)) u_dec (
                .ph        (ph_nxt),
                .cfg       (cfg_nxt),
                .ale       (ale_d),
                .psen_n    (psen_n_d),
                .addr_slot (addr_d)
            );

            // Glitch-free strobe flops, aligned with the phase register.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ale       <= 1'b0;
                    psen_n    <= 1'b1;
                    addr_slot <= 1'b0;
                end else begin
                    ale       <= ale_d;
                    psen_n    <= psen_n_d;
                    addr_slot <= addr_d;
                end
            end
        end else begin : g_comb
            strobe_decode #(.MC_CLKS(MC_CLKS), .ALE_W(ALE_W)) u_dec (
                .ph        (ph_q),
                .cfg       (cfg_q),
                .ale       (ale),
                .psen_n    (psen_n),
                .addr_slot (addr_slot)
            );
        end
    endgenerate

endmodule

// File: rtl/bus_strobe_checker.sv
// Checker for ext_bus_strobe. Watches the ports only, keeping its own
// copy of the configuration captured at each cycle start.
module bus_strobe_checker #(
    parameter int MC_CLKS = 12,
    parameter int ALE_W   = 2,
    localparam int PH_W   = $clog2(MC_CLKS)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      cyc_kind,
    input logic            ale_off,
    input logic            ext_exec,
    input logic            ale,
    input logic            psen_n,
    input logic            addr_slot,
    input logic [PH_W-1:0] cyc_phase
);
    localparam logic [PH_W-1:0] LAST = PH_W'(MC_CLKS - 1);
    localparam logic [PH_W-1:0] HALF = PH_W'(MC_CLKS / 2);
    localparam logic [PH_W-1:0] AW   = PH_W'(ALE_W);

    logic [1:0]      k_seen;
    logic            off_seen, ext_seen;
    logic [PH_W-1:0] hp;

    // Capture the controls the design should use for the coming cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_seen   <= 2'b00;
            off_seen <= 1'b0;
            ext_seen <= 1'b0;
        end else if (cyc_phase == LAST) begin
            k_seen   <= cyc_kind;
            off_seen <= ale_off;
            ext_seen <= ext_exec;
        end
    end

    // Position inside the current half-cycle.
    always_comb hp = (cyc_phase >= HALF) ? cyc_phase - HALF : cyc_phase;

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_phase != LAST) |=> (cyc_phase == $past(cyc_phase) + PH_W'(1))); // R2
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_phase == LAST) |=> (cyc_phase == '0)); // R2
    AST_ALE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (hp < AW)); // R3
    AST_DATA_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (k_seen == 2'b10 && cyc_phase >= HALF) |-> !ale); // R4
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (off_seen && !ext_seen && !k_seen[1]) |-> !ale); // R5
    AST_EXT_KEEPS_ALE: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_seen && cyc_phase == '0) |-> ale); // R6
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale && !psen_n)); // R7
    AST_PSEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (k_seen == 2'b00 || k_seen == 2'b10) |-> psen_n); // R8
    AST_ADDR_COVERS_ALE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> addr_slot); // R9

endmodule

bind ext_bus_strobe bus_strobe_checker #(.MC_CLKS(MC_CLKS), .ALE_W(ALE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_kind  (cyc_kind),
    .ale_off   (ale_off),
    .ext_exec  (ext_exec),
    .ale       (ale),
    .psen_n    (psen_n),
    .addr_slot (addr_slot),
    .cyc_phase (cyc_phase)
);

// File: tb/test_ext_bus_strobe.sv
// Bench for ext_bus_strobe: sweeps every cycle configuration and checks
// every phase against arithmetically computed strobe patterns.
module test_ext_bus_strobe;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cyc_kind = 2'b00;
    logic       ale_off = 1'b0;
    logic       ext_exec = 1'b0;
    logic       ale, psen_n, addr_slot;
    logic [3:0] cyc_phase;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    ext_bus_strobe i_ext_bus_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_kind  (cyc_kind),
        .ale_off   (ale_off),
        .ext_exec  (ext_exec),
        .ale       (ale),
        .psen_n    (psen_n),
        .addr_slot (addr_slot),
        .cyc_phase (cyc_phase)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One machine cycle with the given controls; optionally invert them mid-cycle (R10).
    task automatic run_cycle(input int k, input bit off, input bit ext, input bit scramble);
        cyc_kind = 2'(k);
        ale_off  = off;
        ext_exec = ext;
        for (int p = 0; p < 12; p++) begin
            int  hp;
            bit  second, live, en, e_ale, e_psen_n, e_addr;
            string rq;
            @(negedge clk);
            if (scramble && p == 4) begin
                cyc_kind = ~cyc_kind;
                ale_off  = ~ale_off;
                ext_exec = ~ext_exec;
            end
            hp       = p % 6;
            second   = (p >= 6);
            live     = !(second && k == 2);
            en       = ext || !off || k >= 2;
            e_ale    = live && en && hp < 2;
            e_addr   = live && hp < 3;
            e_psen_n = !((k == 1 || k == 3) && hp >= 3);
            check(scramble ? "R10" : "R2", "phase", cyc_phase, p);
            if (scramble)                    rq = "R10";
            else if (k == 2 && second)       rq = "R4";
            else if (off && !ext && k < 2)   rq = "R5";
            else if (off && ext)             rq = "R6";
            else                             rq = "R3";
            check(rq, "ale", ale, e_ale);
            check(scramble ? "R10" : ((k == 1 || k == 3) ? "R7" : "R8"), "psen_n", psen_n, e_psen_n);
            check(scramble ? "R10" : "R9", "addr_slot", addr_slot, e_addr);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "ale", ale, 0);
        check("R1", "psen_n", psen_n, 1);
        check("R1", "addr_slot", addr_slot, 0);
        check("R1", "phase", cyc_phase, 11);
        rst_n = 1'b1;
        // Full sweep, forward order
        for (int c = 0; c < 16; c++) run_cycle(c % 4, c[2], c[3], 1'b0);
        // Reverse order, so each configuration follows a different predecessor
        for (int c = 15; c >= 0; c--) run_cycle(c / 4, c[0], c[1], 1'b0);
        // R10: controls flipped inside every cycle
        for (int c = 0; c < 16; c++) run_cycle(c % 4, c[2], c[3], 1'b1);
        // Disabled ALE combined with a data cycle, back to back (R4, R5)
        run_cycle(0, 1'b1, 1'b0, 1'b0);
        run_cycle(2, 1'b1, 1'b0, 1'b0);
        run_cycle(1, 1'b1, 1'b0, 1'b0);
        // R1: reset again in mid-cycle
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "ale", ale, 0);
        check("R1", "psen_n", psen_n, 1);
        check("R1", "phase", cyc_phase, 11);
        rst_n = 1'b1;
        run_cycle(3, 1'b0, 1'b0, 1'b0);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule